// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Wrap Counting

This block multiplies two operands and adds the product into a running accumulator. One input picks two's-complement or unsigned arithmetic. Operands narrower than the multiplier's native size are widened before the multiply. In signed mode the top bit is copied upward. In unsigned mode the upper bits are filled with zeros. The native size is the smallest of 9, 18 or 36 bits that holds the operand.

The accumulator has a fixed width and wraps modulo its size. Each time a step crosses the wrap boundary, a one-cycle overflow strobe is raised. A small extension counter steps on these strobes: up in unsigned mode, and up or down by the sign of the addend in signed mode. The counter joined to the accumulator forms a wider result that does not lose the wrapped bits. There is no saturation. A synchronous clear restarts a new accumulation.

Top module: `mac_wide_acc`

## Requirements
- R1: While reset is asserted and after its release, `acc_out`, `ovf_pulse` and `wide_out` are zero until the first accepted operation.
- R2: A cycle with `acc_clear` high sets `acc_out`, `ovf_pulse` and `wide_out` to zero at the next clock edge, even if `in_valid` is also high.
- R3: A cycle with `in_valid` low and `acc_clear` low leaves `acc_out` and `wide_out` unchanged and drives `ovf_pulse` low after the next edge.
- R4: With `signed_mode` = 0, an accepted operation sets `acc_out` to (acc + a·b) mod 2^ACC_W, with both operands taken as unsigned. ACC_W = 2·NAT_W + 4, where NAT_W is the smallest of 9, 18, 36 that is at least OP_W.
- R5: With `signed_mode` = 1, both operands are two's-complement values. Sign extension keeps their value. The signed product is added to `acc_out` modulo 2^ACC_W.
- R6: In unsigned mode, `ovf_pulse` is high for exactly the one cycle after an operation whose sum carries out of bit ACC_W−1.
- R7: In signed mode, `ovf_pulse` is high for the one cycle after an operation where both summands have the same sign and the result has the other sign.
- R8: In unsigned mode, each overflow adds one to an EXT_W-bit wrap counter. `wide_out` equals the counter concatenated above `acc_out`, which is the exact sum modulo 2^(EXT_W+ACC_W).
- R9: In signed mode, the counter adds one on a wrap with a non-negative addend and subtracts one on a wrap with a negative addend. `wide_out` equals counter·2^ACC_W plus the sign-extended `acc_out`, which is the exact signed sum modulo 2^(EXT_W+ACC_W). `signed_mode` is held constant between clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are accepted this cycle |
| op_a | input | OP_W | First operand |
| op_b | input | OP_W | Second operand |
| signed_mode | input | 1 | 1 = two's complement, 0 = unsigned |
| acc_clear | input | 1 | Synchronous clear, wins over in_valid |
| acc_out | output | ACC_W | Accumulator value |
| ovf_pulse | output | 1 | One-cycle wrap strobe |
| wide_out | output | EXT_W+ACC_W | Accumulator widened by the wrap counter |

## Verification
The hardest case to reach is a wrap in the negative direction in signed mode. The accumulator has four guard bits, so it takes over a hundred near-maximum products to reach either boundary, and the run must first cross upward and then come back down past both zero and the lower limit. The bench reaches it with directed runs of the largest positive products followed by long runs of the most negative product. It then runs long random blocks drawn towards the operand extremes, with periodic idle cycles, and checks each step against a wide reference sum.

// File: rtl/mac_pkg.sv
package mac_pkg;
   localparam int ACC_GUARD = 4;

   typedef enum logic [1:0] {
      STEP_NONE = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2
   } step_e;

   function automatic int native_width(input int w);
      if (w <= 9)       return 9;
      else if (w <= 18) return 18;
      else              return 36;
   endfunction
endpackage

// File: rtl/mac_widen.sv
module mac_widen #(
   parameter int IN_W  = 12,
   parameter int OUT_W = 19
) (
   input  logic [IN_W-1:0]  din,
   input  logic             sgn,
   output logic [OUT_W-1:0] dout
);
   localparam int PAD_W = OUT_W - IN_W;

   if (PAD_W < 1) begin : g_bad_width
      $error("mac_widen: output must be wider than input");
   end else begin : g_pad
      logic fill;
      assign fill = sgn & din[IN_W-1];
      assign dout = {{PAD_W{fill}}, din};
   end
endmodule

// File: rtl/mac_accum.sv
module mac_accum import mac_pkg::*; #(
   parameter int NAT_W = 18,
   parameter int ACC_W = 40
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             valid,
   input  logic             sgn,
   input  logic [NAT_W:0]   a_x,
   input  logic [NAT_W:0]   b_x,
   output logic [ACC_W-1:0] acc_q,
   output logic             ovf_q,
   output logic             mode_q,
   output step_e            step
);
   localparam int PROD_W = 2 * NAT_W + 2;
   localparam int TOP    = ACC_W - 1;

   logic signed [PROD_W-1:0] prod;
   logic [ACC_W-1:0]         addend;
   logic [ACC_W-1:0]         sum;
   logic                     carry;
   logic                     wrap;

   if (ACC_W < PROD_W) begin : g_bad_acc
      $error("mac_accum: accumulator narrower than product");
   end

   assign prod   = $signed(a_x) * $signed(b_x);
   assign addend = ACC_W'(prod);
   assign {carry, sum} = {1'b0, acc_q} + {1'b0, addend};

   always_comb begin
      if (sgn) wrap = (acc_q[TOP] == addend[TOP]) && (sum[TOP] != acc_q[TOP]);
      else     wrap = carry;
   end

   always_comb begin
      step = STEP_NONE;
      if (valid && !clr && wrap)
         step = (sgn && addend[TOP]) ? STEP_DOWN : STEP_UP;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q  <= '0;
         ovf_q  <= 1'b0;
         mode_q <= 1'b0;
      end else if (clr) begin
         acc_q  <= '0;
         ovf_q  <= 1'b0;
         mode_q <= sgn;
      end else if (valid) begin
         acc_q  <= sum;
         ovf_q  <= wrap;
         mode_q <= sgn;
      end else begin
         ovf_q  <= 1'b0;
      end
   end
endmodule

// File: rtl/mac_ext_count.sv
module mac_ext_count import mac_pkg::*; #(
   parameter int EXT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  step_e            step,
   output logic [EXT_W-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (rst || clr) begin
         cnt <= '0;
      end else begin
         case (step)
            STEP_UP:   cnt <= cnt + 1'b1;
            STEP_DOWN: cnt <= cnt - 1'b1;
            default:   cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/mac_wide_acc.sv
module mac_wide_acc import mac_pkg::*; #(
   parameter  int OP_W   = 12,
   parameter  int EXT_W  = 8,
   localparam int NAT_W  = native_width(OP_W),
   localparam int ACC_W  = 2 * NAT_W + ACC_GUARD,
   localparam int WIDE_W = EXT_W + ACC_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [OP_W-1:0]   op_a,
   input  logic [OP_W-1:0]   op_b,
   input  logic              signed_mode,
   input  logic              acc_clear,
   output logic [ACC_W-1:0]  acc_out,
   output logic              ovf_pulse,
   output logic [WIDE_W-1:0] wide_out
);
   if (OP_W < 2 || OP_W > 36) begin : g_bad_op
      $error("mac_wide_acc: OP_W must lie in 2..36");
   end
   if (EXT_W < 1) begin : g_bad_ext
      $error("mac_wide_acc: EXT_W must be at least 1");
   end

   logic [NAT_W:0]   a_x;
   logic [NAT_W:0]   b_x;
   logic             mode_q;
   step_e            step;
   logic [EXT_W-1:0] ext_cnt;
   logic             acc_neg;

   mac_widen #(.IN_W(OP_W), .OUT_W(NAT_W + 1)) u_widen_a (
      .din(op_a), .sgn(signed_mode), .dout(a_x));

   mac_widen #(.IN_W(OP_W), .OUT_W(NAT_W + 1)) u_widen_b (
      .din(op_b), .sgn(signed_mode), .dout(b_x));

   mac_accum #(.NAT_W(NAT_W), .ACC_W(ACC_W)) u_accum (
      .clk(clk), .rst(rst), .clr(acc_clear), .valid(in_valid),
      .sgn(signed_mode), .a_x(a_x), .b_x(b_x),
      .acc_q(acc_out), .ovf_q(ovf_pulse), .mode_q(mode_q), .step(step));

   mac_ext_count #(.EXT_W(EXT_W)) u_ext (
      .clk(clk), .rst(rst), .clr(acc_clear), .step(step), .cnt(ext_cnt));

   assign acc_neg  = mode_q & acc_out[ACC_W-1];
   assign wide_out = {ext_cnt, {ACC_W{1'b0}}} + {{EXT_W{acc_neg}}, acc_out};
endmodule

// File: rtl/mac_wide_acc_chk.sv
module mac_wide_acc_chk #(
   parameter int ACC_W = 40,
   parameter int EXT_W = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic             signed_mode,
   input logic             acc_clear,
   input logic [ACC_W-1:0] acc_out,
   input logic             ovf_pulse,
   input logic [EXT_W-1:0] ext_cnt
);
   assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
      acc_clear |=> (acc_out == '0) && !ovf_pulse && (ext_cnt == '0));

   assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (!in_valid && !acc_clear) |=> $stable(acc_out) && !ovf_pulse && $stable(ext_cnt));

   assert_uns_drop_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !acc_clear && !signed_mode) |=> (ovf_pulse == (acc_out < $past(acc_out))));

   assert_uns_single_R6: assert property (@(posedge clk) disable iff (rst)
      (ovf_pulse && !signed_mode && in_valid && !acc_clear) |=> !ovf_pulse);

   assert_ext_step_R8: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !acc_clear && !signed_mode) |=>
         (ext_cnt == EXT_W'($past(ext_cnt) + (ovf_pulse ? 1 : 0))));

   assert_ext_step_R9: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !acc_clear && signed_mode) |=>
         (ovf_pulse ? ((ext_cnt == EXT_W'($past(ext_cnt) + 1)) ||
                       (ext_cnt == EXT_W'($past(ext_cnt) - 1)))
                    : (ext_cnt == $past(ext_cnt))));
endmodule

bind mac_wide_acc mac_wide_acc_chk #(.ACC_W(ACC_W), .EXT_W(EXT_W)) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .signed_mode(signed_mode),
   .acc_clear(acc_clear), .acc_out(acc_out), .ovf_pulse(ovf_pulse),
   .ext_cnt(ext_cnt));

// File: tb/test_mac_wide_acc.sv
module test_mac_wide_acc;
   localparam int OP_W   = 8;
   localparam int EXT_W  = 8;
   localparam int ACC_W  = 22;   // 2*9+4
   localparam int WIDE_W = 30;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              in_valid = 1'b0;
   logic [OP_W-1:0]   op_a = '0;
   logic [OP_W-1:0]   op_b = '0;
   logic              signed_mode = 1'b0;
   logic              acc_clear = 1'b0;
   logic [ACC_W-1:0]  acc_out;
   logic              ovf_pulse;
   logic [WIDE_W-1:0] wide_out;

   int errors = 0;
   int checks = 0;
   bit done = 0;
   logic [WIDE_W-1:0] model = '0;
   bit model_sgn = 0;

   always #5 clk = ~clk;

   mac_wide_acc #(.OP_W(OP_W), .EXT_W(EXT_W)) i_mac_wide_acc (
      .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .signed_mode(signed_mode), .acc_clear(acc_clear),
      .acc_out(acc_out), .ovf_pulse(ovf_pulse), .wide_out(wide_out));

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int opval(input logic [OP_W-1:0] v, input bit s);
      return s ? int'($signed(v)) : int'(v);
   endfunction

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   task automatic step(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b,
                       input bit v, input bit c, input bit s);
      int p;
      longint sacc;
      longint uacc;
      bit exp_ovf;
      @(negedge clk);
      op_a = a; op_b = b; in_valid = v; acc_clear = c; signed_mode = s;
      exp_ovf = 0;
      if (c) begin
         model = '0;
         model_sgn = s;
      end else if (v) begin
         p    = opval(a, s) * opval(b, s);
         uacc = longint'(model[ACC_W-1:0]);
         sacc = longint'($signed(model[ACC_W-1:0]));
         if (s) exp_ovf = (sacc + p > (64'sd1 <<< (ACC_W-1)) - 1) ||
                          (sacc + p < -(64'sd1 <<< (ACC_W-1)));
         else   exp_ovf = (uacc + p) >= (64'sd1 <<< ACC_W);
         model = model + WIDE_W'(p);
      end
      @(posedge clk);
      #2;
      if (c) begin
         check("R2 clear acc", acc_out, 0);
         check("R2 clear ovf", ovf_pulse, 0);
         check("R2 clear wide", wide_out, 0);
      end else if (!v) begin
         check("R3 hold acc", acc_out, model[ACC_W-1:0]);
         check("R3 idle ovf", ovf_pulse, 0);
         check("R3 hold wide", wide_out, model);
      end else if (s) begin
         check("R5 signed acc", acc_out, model[ACC_W-1:0]);
         check("R7 signed ovf", ovf_pulse, exp_ovf);
         check("R9 signed wide", wide_out, model);
      end else begin
         check("R4 unsigned acc", acc_out, model[ACC_W-1:0]);
         check("R6 unsigned ovf", ovf_pulse, exp_ovf);
         check("R8 unsigned wide", wide_out, model);
      end
   endtask

   function automatic logic [OP_W-1:0] pick();
      int r = $urandom_range(0, 3);
      if (r == 0) return 8'h7F;
      if (r == 1) return 8'h80;
      if (r == 2) return 8'hFF;
      return OP_W'($urandom);
   endfunction

   initial begin
      #1_500_000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(posedge clk);
      #2;
      check("R1 reset acc", acc_out, 0);
      check("R1 reset ovf", ovf_pulse, 0);
      check("R1 reset wide", wide_out, 0);
      @(negedge clk);
      rst = 1'b0;
      @(posedge clk); #2;
      check("R1 post-reset acc", acc_out, 0);
      check("R1 post-reset wide", wide_out, 0);

      // unsigned: maximum products until the accumulator wraps, then idle
      step(0, 0, 0, 1, 0);
      repeat (70) step(8'hFF, 8'hFF, 1, 0, 0);
      repeat (3) step(8'hFF, 8'hFF, 0, 0, 0);
      // clear wins over valid
      step(8'hFF, 8'hFF, 1, 1, 0);

      // signed: climb past the top, then fall past zero and the bottom
      step(0, 0, 0, 1, 1);
      repeat (140) step(8'h7F, 8'h7F, 1, 0, 1);
      repeat (420) step(8'h80, 8'h7F, 1, 0, 1);
      repeat (10) step(8'h80, 8'h80, 1, 0, 1);
      repeat (2) step(8'h80, 8'h7F, 0, 0, 1);

      // random blocks, mode fixed between clears
      for (int blk = 0; blk < 8; blk++) begin
         bit s = bit'(blk % 2);
         step(0, 0, 0, 1, s);
         for (int i = 0; i < 1200; i++)
            step(pick(), pick(), ($urandom_range(0, 9) != 0), 0, s);
      end
      step(0, 0, 1, 1, 1);
      summary();
   end
endmodule